// File: doc/BRIEF.md
# Four-Plane Framebuffer Byte Write Unit

This block is the write path of a four-plane, 16-colour bitmap store. Each pixel is held as one bit in each of four planes, and eight horizontally adjacent pixels share one byte address. A write goes through four per-plane byte latches and a 4-bit colour register. Every bit set in the write pattern takes the colour register's bit for that plane. Every clear bit keeps the bit already in the latch, which holds what was last read from that byte.

A front end takes one command at a time from a single-cycle strobe. The commands are: set one pixel at (x, y), write an 8-bit pattern at a byte address, or fill the whole store with one colour. The front end keeps a copy of the colour register and writes the register only when the colour changes. It drops patterns that are all zero. It reads the target byte into the latches only when the pattern leaves some pixels untouched. While a command is in progress, `busy_o` is high.

The geometry is set by parameters, with a small default. A 640x480 screen (80 bytes per row, 38400 bytes per plane) uses the same logic. A combinational peek port returns the four plane bits of any pixel.

Top module: `fb_latch_writer`

## Requirements
- R1: After reset `busy_o` is low and the colour register and its cached copy are both 0, so a fill with colour 0 then takes exactly BYTES busy cycles.
- R2: Pixel (x, y) lives at byte address y*BPR + x/8 (BPR = H_PIX/8), in bit 7 - (x mod 8), so bit 7 is the leftmost pixel. A pixel command changes only that pixel.
- R3: On a byte write, for each plane p, bit i becomes colour bit p if pattern bit i is 1. Otherwise it keeps its stored value.
- R4: A pattern other than 0x00 and 0xFF first spends one cycle loading the four latches from the target byte, then one write cycle.
- R5: A 0xFF pattern skips the latch load and uses a single write cycle.
- R6: A 0x00 pattern (by byte or pixel command) leaves `busy_o` low, changes no stored bit and leaves the colour register unchanged.
- R7: The colour register is rewritten, at a cost of one extra busy cycle before the data cycles, only when the requested colour differs from the cached copy.
- R8: A fill writes the colour into every pixel of every plane, one byte address per cycle from 0 to BYTES-1, after a colour cycle if needed.
- R9: Command code 3 is ignored: `busy_o` stays low and the store is unchanged. The command codes are 0 pixel, 1 byte write, 2 fill.
- R10: `peek_planes_o[p]` is the stored bit of plane p for the pixel at (`peek_x_i`, `peek_y_i`).
- R11: A strobe while `busy_o` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | One-cycle command strobe |
| cmd_op_i | input | 2 | 0 pixel, 1 byte write, 2 fill, 3 none |
| cmd_x_i | input | X_W | Pixel column |
| cmd_y_i | input | Y_W | Pixel row |
| cmd_addr_i | input | A_W | Byte address for byte write |
| cmd_pat_i | input | 8 | Byte write pattern, bit 7 leftmost |
| cmd_color_i | input | 4 | Requested colour, bit p for plane p |
| busy_o | output | 1 | Command in progress |
| peek_x_i | input | X_W | Peek column |
| peek_y_i | input | Y_W | Peek row |
| peek_planes_o | output | 4 | Plane bits of the peeked pixel |

## Verification
The assertions assume that a strobe is only meaningful while `busy_o` is low. They also assume that byte addresses and coordinates stay inside the configured geometry. The stimulus keeps to both rules: it drives every command at a falling edge and waits for `busy_o` to fall before the next one. The single exception is one deliberate strobe during a fill, which checks R11. Every address and coordinate is generated inside the 64x16 default screen. The bench sweeps the whole store through the peek port after each phase.

// File: rtl/fb_pkg.sv
package fb_pkg;
  localparam int NPLANE = 4;
  typedef enum logic [1:0] {
    OP_PIXEL = 2'd0,
    OP_BYTE  = 2'd1,
    OP_FILL  = 2'd2,
    OP_NONE  = 2'd3
  } fb_op_e;
  typedef enum logic [2:0] {
    S_IDLE, S_COLOR, S_READ, S_WRITE, S_FILL
  } fb_st_e;
  typedef logic [NPLANE-1:0]      color_t;
  typedef logic [NPLANE-1:0][7:0] planes_t;
endpackage

// File: rtl/fb_plane_store.sv
module fb_plane_store
  import fb_pkg::*;
#(
  parameter int BYTES = 128,
  parameter int A_W   = 7
) (
  input  logic           clk_i,
  input  logic           we_i,
  input  logic [A_W-1:0] addr_i,
  input  planes_t        wdata_i,
  output planes_t        rdata_o,
  input  logic [A_W-1:0] paddr_i,
  output planes_t        pdata_o
);
  logic in_range;
  assign in_range = {1'b0, addr_i} < (A_W+1)'(BYTES);

  for (genvar p = 0; p < NPLANE; p++) begin : g_plane
    logic [7:0] mem [BYTES];
    always_ff @(posedge clk_i) begin
      if (we_i && in_range) mem[addr_i] <= wdata_i[p];
    end
    assign rdata_o[p] = mem[addr_i];
    assign pdata_o[p] = mem[paddr_i];
  end
endmodule

// File: rtl/fb_latch_merge.sv
module fb_latch_merge
  import fb_pkg::*;
#(
  parameter logic [NPLANE-1:0] ENA_MASK = '1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       creg_we_i,
  input  color_t     creg_d_i,
  input  logic       ld_i,
  input  planes_t    rdata_i,
  input  logic [7:0] pat_i,
  output planes_t    wdata_o,
  output color_t     creg_o
);
  planes_t latch_q;
  color_t  creg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      creg_q  <= '0;
      latch_q <= '0;
    end else begin
      if (creg_we_i) creg_q <= creg_d_i;
      if (ld_i) latch_q <= rdata_i;
    end
  end

  for (genvar p = 0; p < NPLANE; p++) begin : g_merge
    if (ENA_MASK[p]) begin : g_sub
      assign wdata_o[p] = (pat_i & {8{creg_q[p]}}) | (~pat_i & latch_q[p]);
    end else begin : g_keep
      assign wdata_o[p] = latch_q[p];
    end
  end

  assign creg_o = creg_q;
endmodule

// File: rtl/fb_draw_seq.sv
module fb_draw_seq
  import fb_pkg::*;
#(
  parameter int X_W   = 6,
  parameter int Y_W   = 4,
  parameter int A_W   = 7,
  parameter int BPR   = 8,
  parameter int BYTES = 128
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cmd_valid_i,
  input  logic [1:0]     cmd_op_i,
  input  logic [X_W-1:0] cmd_x_i,
  input  logic [Y_W-1:0] cmd_y_i,
  input  logic [A_W-1:0] cmd_addr_i,
  input  logic [7:0]     cmd_pat_i,
  input  color_t         cmd_color_i,
  output logic           busy_o,
  output logic           creg_we_o,
  output color_t         creg_d_o,
  output logic           rd_o,
  output logic           wr_o,
  output logic [A_W-1:0] addr_o,
  output logic [7:0]     pat_o
);
  localparam logic [A_W-1:0] LAST = A_W'(BYTES - 1);

  fb_st_e         st_q;
  logic [A_W-1:0] addr_q;
  logic [7:0]     pat_q;
  color_t         col_q, cache_q;
  logic           fill_q;

  fb_op_e         op;
  logic [A_W-1:0] sel_addr;
  logic [7:0]     sel_pat;
  logic           col_diff;

  assign op       = fb_op_e'(cmd_op_i);
  assign col_diff = cmd_color_i != cache_q;
  always_comb begin
    if (op == OP_PIXEL) begin
      sel_addr = A_W'(cmd_y_i) * A_W'(BPR) + A_W'(cmd_x_i >> 3);
      sel_pat  = 8'h80 >> cmd_x_i[2:0];
    end else begin
      sel_addr = cmd_addr_i;
      sel_pat  = cmd_pat_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      addr_q  <= '0;
      pat_q   <= '0;
      col_q   <= '0;
      cache_q <= '0;
      fill_q  <= 1'b0;
    end else begin
      unique case (st_q)
        S_IDLE: if (cmd_valid_i) begin
          unique case (op)
            OP_PIXEL, OP_BYTE: if (sel_pat != 8'h00) begin
              addr_q <= sel_addr;
              pat_q  <= sel_pat;
              col_q  <= cmd_color_i;
              fill_q <= 1'b0;
              if (col_diff)              st_q <= S_COLOR;
              else if (sel_pat == 8'hFF) st_q <= S_WRITE;
              else                       st_q <= S_READ;
            end
            OP_FILL: begin
              addr_q <= '0;
              pat_q  <= 8'hFF;
              col_q  <= cmd_color_i;
              fill_q <= 1'b1;
              st_q   <= col_diff ? S_COLOR : S_FILL;
            end
            default: ;
          endcase
        end
        S_COLOR: begin
          cache_q <= col_q;
          if (fill_q)              st_q <= S_FILL;
          else if (pat_q == 8'hFF) st_q <= S_WRITE;
          else                     st_q <= S_READ;
        end
        S_READ:  st_q <= S_WRITE;
        S_WRITE: st_q <= S_IDLE;
        S_FILL: begin
          if (addr_q == LAST) st_q <= S_IDLE;
          else                addr_q <= addr_q + 1'b1;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o    = st_q != S_IDLE;
  assign creg_we_o = st_q == S_COLOR;
  assign creg_d_o  = col_q;
  assign rd_o      = st_q == S_READ;
  assign wr_o      = (st_q == S_WRITE) || (st_q == S_FILL);
  assign addr_o    = addr_q;
  assign pat_o     = pat_q;
endmodule

// File: rtl/fb_latch_writer.sv
module fb_latch_writer
  import fb_pkg::*;
#(
  parameter int                H_PIX    = 64,
  parameter int                V_PIX    = 16,
  parameter logic [NPLANE-1:0] ENA_MASK = '1,
  parameter int                X_W      = $clog2(H_PIX),
  parameter int                Y_W      = $clog2(V_PIX),
  parameter int                A_W      = $clog2(H_PIX / 8 * V_PIX)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cmd_valid_i,
  input  logic [1:0]     cmd_op_i,
  input  logic [X_W-1:0] cmd_x_i,
  input  logic [Y_W-1:0] cmd_y_i,
  input  logic [A_W-1:0] cmd_addr_i,
  input  logic [7:0]     cmd_pat_i,
  input  logic [3:0]     cmd_color_i,
  output logic           busy_o,
  input  logic [X_W-1:0] peek_x_i,
  input  logic [Y_W-1:0] peek_y_i,
  output logic [3:0]     peek_planes_o
);
  localparam int BPR   = H_PIX / 8;
  localparam int BYTES = BPR * V_PIX;

  logic           creg_we, rd_en, wr_en;
  color_t         creg_d, creg;
  logic [A_W-1:0] addr, peek_addr;
  logic [7:0]     wpat;
  planes_t        rdata, wdata, pdata;

  fb_draw_seq #(
    .X_W(X_W), .Y_W(Y_W), .A_W(A_W), .BPR(BPR), .BYTES(BYTES)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_valid_i(cmd_valid_i),
    .cmd_op_i   (cmd_op_i),
    .cmd_x_i    (cmd_x_i),
    .cmd_y_i    (cmd_y_i),
    .cmd_addr_i (cmd_addr_i),
    .cmd_pat_i  (cmd_pat_i),
    .cmd_color_i(cmd_color_i),
    .busy_o     (busy_o),
    .creg_we_o  (creg_we),
    .creg_d_o   (creg_d),
    .rd_o       (rd_en),
    .wr_o       (wr_en),
    .addr_o     (addr),
    .pat_o      (wpat)
  );

  fb_latch_merge #(.ENA_MASK(ENA_MASK)) u_merge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .creg_we_i(creg_we),
    .creg_d_i (creg_d),
    .ld_i     (rd_en),
    .rdata_i  (rdata),
    .pat_i    (wpat),
    .wdata_o  (wdata),
    .creg_o   (creg)
  );

  assign peek_addr = A_W'(peek_y_i) * A_W'(BPR) + A_W'(peek_x_i >> 3);

  fb_plane_store #(.BYTES(BYTES), .A_W(A_W)) u_store (
    .clk_i  (clk_i),
    .we_i   (wr_en),
    .addr_i (addr),
    .wdata_i(wdata),
    .rdata_o(rdata),
    .paddr_i(peek_addr),
    .pdata_o(pdata)
  );

  for (genvar p = 0; p < NPLANE; p++) begin : g_peek
    assign peek_planes_o[p] = pdata[p][3'(~peek_x_i[2:0])];
  end
endmodule

// File: rtl/fb_latch_writer_chk.sv
module fb_latch_writer_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cmd_valid_i,
  input logic [1:0] cmd_op_i,
  input logic [7:0] cmd_pat_i,
  input logic       busy_o,
  input logic       creg_we_i,
  input logic [3:0] creg_i,
  input logic       rd_i,
  input logic       wr_i,
  input logic [7:0] pat_i
);
  logic take;
  assign take = cmd_valid_i && !busy_o;

  p_drop_empty_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && cmd_op_i == 2'd1 && cmd_pat_i == 8'h00) |=> !busy_o);

  p_ignore_none_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && cmd_op_i == 2'd3) |=> !busy_o);

  p_fill_starts_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && cmd_op_i == 2'd2) |=> busy_o);

  p_creg_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !creg_we_i |=> $stable(creg_i));

  p_load_then_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> (wr_i && $stable(pat_i)));

  p_full_no_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |-> (pat_i != 8'hFF && pat_i != 8'h00));

  p_rd_wr_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i && wr_i));

  p_busy_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !wr_i) |=> busy_o);
endmodule

bind fb_latch_writer fb_latch_writer_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cmd_valid_i(cmd_valid_i),
  .cmd_op_i   (cmd_op_i),
  .cmd_pat_i  (cmd_pat_i),
  .busy_o     (busy_o),
  .creg_we_i  (creg_we),
  .creg_i     (creg),
  .rd_i       (rd_en),
  .wr_i       (wr_en),
  .pat_i      (wpat)
);

// File: tb/fb_latch_writer_tb.sv
`timescale 1ns/1ps
module fb_latch_writer_tb;
  localparam int H = 64, V = 16, BPR = H / 8, BYTES = BPR * V;
  localparam int X_W = 6, Y_W = 4, A_W = 7;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = '0;
  logic [X_W-1:0] cmd_x = '0, peek_x = '0;
  logic [Y_W-1:0] cmd_y = '0, peek_y = '0;
  logic [A_W-1:0] cmd_addr = '0;
  logic [7:0] cmd_pat = '0;
  logic [3:0] cmd_col = '0;
  logic busy;
  logic [3:0] peek;

  int vectors = 0, errors = 0;
  bit done = 0;
  logic [7:0] ref_mem [4][BYTES];
  logic [3:0] cache = '0;

  always #2 clk = ~clk;

  fb_latch_writer u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_x_i(cmd_x), .cmd_y_i(cmd_y), .cmd_addr_i(cmd_addr), .cmd_pat_i(cmd_pat),
    .cmd_color_i(cmd_col), .busy_o(busy), .peek_x_i(peek_x), .peek_y_i(peek_y),
    .peek_planes_o(peek)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  task automatic run_cmd(input logic [1:0] op, input int x, input int y, input int addr,
                         input logic [7:0] pat, input logic [3:0] col, output int n);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_x = X_W'(x); cmd_y = Y_W'(y);
    cmd_addr = A_W'(addr); cmd_pat = pat; cmd_col = col;
    @(negedge clk);
    cmd_valid = 1'b0;
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  function automatic int cost(input logic [7:0] pat, input logic [3:0] col);
    if (pat == 8'h00) return 0;
    return ((col != cache) ? 1 : 0) + ((pat != 8'hFF) ? 1 : 0) + 1;
  endfunction

  function automatic void model_write(input int a, input logic [7:0] pat, input logic [3:0] col);
    if (pat == 8'h00) return;
    for (int p = 0; p < 4; p++)
      ref_mem[p][a] = (pat & {8{col[p]}}) | (~pat & ref_mem[p][a]);
    cache = col;
  endfunction

  task automatic do_byte(input int a, input logic [7:0] pat, input logic [3:0] col, input string tag);
    int n, e;
    e = cost(pat, col);
    run_cmd(2'd1, 0, 0, a, pat, col, n);
    check(n == e, tag, n, e);
    model_write(a, pat, col);
  endtask

  task automatic do_pixel(input int x, input int y, input logic [3:0] col);
    int n, e, a;
    logic [7:0] pat;
    pat = 8'h80 >> (x % 8);
    a = y * BPR + x / 8;
    e = cost(pat, col);
    run_cmd(2'd0, x, y, 0, 8'h00, col, n);
    check(n == e, "R2 pixel busy cycles", n, e);
    model_write(a, pat, col);
  endtask

  task automatic do_fill(input logic [3:0] col, input string tag);
    int n, e;
    e = BYTES + ((col != cache) ? 1 : 0);
    run_cmd(2'd2, 0, 0, 0, 8'h00, col, n);
    check(n == e, tag, n, e);
    for (int a = 0; a < BYTES; a++) model_write(a, 8'hFF, col);
  endtask

  task automatic sweep(input string tag);
    for (int y = 0; y < V; y++)
      for (int x = 0; x < H; x++) begin
        logic [3:0] e;
        peek_x = X_W'(x); peek_y = Y_W'(y);
        #0.1;
        for (int p = 0; p < 4; p++) e[p] = ref_mem[p][y * BPR + x / 8][7 - x % 8];
        check(peek == e, tag, peek, e);
      end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R1 busy low in reset", busy, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R1 busy low after reset", busy, 0);

    do_fill(4'h0, "R1 fill colour 0 needs no colour cycle");
    sweep("R10 R8 peek after fill 0");
    do_fill(4'hA, "R8 fill colour A busy");
    sweep("R8 R10 all pixels colour A");

    for (int i = 0; i < 64; i++) do_pixel(i, i % V, 4'(i));
    do_pixel(63, 15, 4'h3);
    do_pixel(0, 0, 4'h3);
    sweep("R2 pixel mapping and neighbours kept");

    do_byte(5, 8'h5A, 4'h3, "R4 partial pattern same colour");
    do_byte(5, 8'hA5, 4'h3, "R7 no colour cycle when unchanged");
    do_byte(6, 8'hFF, 4'h3, "R5 full pattern single cycle");
    do_byte(7, 8'hFF, 4'h9, "R5 R7 full pattern with colour change");
    do_byte(8, 8'h00, 4'h6, "R6 empty pattern dropped");
    sweep("R6 empty write changed nothing");
    do_byte(8, 8'h0F, 4'h6, "R6 R7 colour register kept after empty write");
    do_byte(9, 8'h81, 4'h6, "R4 partial pattern edges");
    run_cmd(2'd0, 12, 3, 0, 8'h00, 4'h6, n);
    check(n == 2, "R2 pixel same colour cost", n, 2);
    model_write(3 * BPR + 1, 8'h08, 4'h6);
    sweep("R3 merge of pattern and prior content");

    run_cmd(2'd3, 5, 5, 20, 8'hFF, 4'hF, n);
    check(n == 0, "R9 code 3 no busy", n, 0);
    sweep("R9 code 3 changed nothing");

    // strobe during a fill
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd2; cmd_col = 4'h5;
    @(negedge clk);
    cmd_valid = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd0; cmd_x = 6'd9; cmd_y = 4'd2; cmd_col = 4'h2;
    @(negedge clk);
    cmd_valid = 1'b0;
    n = 2;
    while (busy) begin n++; @(negedge clk); end
    check(n == BYTES + 1, "R11 fill length with stray strobe", n, BYTES + 1);
    for (int a = 0; a < BYTES; a++) model_write(a, 8'hFF, 4'h5);
    sweep("R11 stray strobe ignored");

    for (int a = 0; a < BYTES; a++)
      do_byte(a, 8'((a * 37 + 11) & 8'hFF), 4'(a * 7), "R3 R4 R5 R7 byte sweep cost");
    sweep("R3 full byte sweep");

    finish_run();
  end
endmodule